// File: doc/BRIEF.md
# ECC Patrol Scrubber with Error Statistics

This block walks through every word of a memory protected by a single-error-correct, double-error-detect code, one pass at a time. Each word is 72 bits: 64 data bits and 8 check bits. A programmable interval timer starts each pass, typically set to about one millisecond of clock cycles. The scrubber takes memory slots only when an external arbiter grants them, so normal traffic always comes first.

Each word read back is classified as clean, single-bit error or double-bit error. A word with a single-bit error has the corrected word written back to the same address. A word with a double-bit error is counted and flagged but is never rewritten. Two saturating counters record the errors found. A latch records the address of the first failing word. One-cycle pulses on two status pins can drive an interrupt. Software reads the counters and the latch through a small register read port, and reading a counter clears it.

The request/grant pair is the only handshake, and back-pressure comes only from the grant. While `scrub_req` is high and `scrub_gnt` is low, the scrubber holds its request and its address, and it waits as long as it must. The memory access happens in the cycle where both are high.

Top module: `ecc_scrubber`

## Requirements
- R1: Code word layout. Bit 0 holds even parity over all 72 bits. The check bits sit at bit positions 1, 2, 4, 8, 16, 32 and 64, and the data bits fill the remaining positions in ascending order. The syndrome is the XOR of the indices of all set bits. Odd parity marks a single-bit error at the syndrome position (position 0 when the syndrome is zero). Even parity with a nonzero syndrome marks a double-bit error.
- R2: When `scrub_interval` is N > 0, a new pass becomes due every N cycles. With a continuous grant and a pass shorter than N, successive reads of address 0 are exactly N cycles apart. When N = 0 no pass is ever started.
- R3: `scrub_req` stays high with `mem_addr` stable until `scrub_gnt` is seen high. A memory read or write is issued only in a cycle where both are high. Read and write are never issued together, and read data is taken on the following cycle.
- R4: Each pass reads addresses 0 through 2^ADDR_W-1 in ascending order, and a new pass begins again at address 0.
- R5: After a single-bit error is found, the corrected word is written to the same address before the next read. After a double-bit error, no write is issued.
- R6: `err_single_pulse` and `err_double_pulse` are high for exactly one cycle. That cycle is two cycles after the read cycle of the failing word.
- R7: The single-error and double-error counters are CNT_W bits wide and stop at all-ones instead of wrapping.
- R8: A read of the register port with `stat_rd_en` high in cycle n returns its data on `stat_rd_data` from cycle n+1 onward. Select 0 returns the single-error count and select 1 the double-error count, both zero-extended. Reading a counter clears it. If an error is counted in the same cycle as the read, the old value is returned and the counter restarts at 1.
- R9: Select 2 returns 0x8000 ORed with the address of the first failing word since the last counter read, or 0 when no word has failed since then. Reading either counter releases this latch, and it holds its value until that happens.
- R10: If the timer expires while a pass is running, the next pass starts right after the current one ends. With a continuous grant, the read of address 0 comes 3 cycles after the read of the last address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_interval | input | TIMER_W | Cycles between pass starts; 0 disables |
| scrub_req | output | 1 | Request for a memory slot |
| scrub_gnt | input | 1 | Slot granted by the arbiter |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe (write-back) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 72 | Corrected code word to write |
| mem_rdata | input | 72 | Code word returned one cycle after a read |
| err_single_pulse | output | 1 | One-cycle pulse for a single-bit error |
| err_double_pulse | output | 1 | One-cycle pulse for a double-bit error |
| stat_rd_en | input | 1 | Register read strobe |
| stat_sel | input | 2 | Register select: 0 single count, 1 double count, 2 first-failure |
| stat_rd_data | output | 16 | Registered read data |

## Verification
Each result has a fixed due cycle relative to the memory read that caused it.
- The status pulse appears two cycles after the read cycle.
- The write-back is due before the next read.
- Register data appears one cycle after the read strobe.
- The read of address 0 in a follow-on pass comes three cycles after the read of the last address.

A behavioural model in the bench keeps a clean copy of every word and classifies each read by the number of bits that differ from it. From that it schedules the expected pulse cycle, the expected write-back and the expected counter and latch values, and it compares them on every clock. Counter reads are issued only while the scrubber is idle, so no count can change between the model's update and the register capture.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

  localparam int CW_W   = 72;
  localparam int STAT_W = 16;

  localparam logic [1:0] SEL_SB   = 2'd0;
  localparam logic [1:0] SEL_DB   = 2'd1;
  localparam logic [1:0] SEL_FAIL = 2'd2;

  typedef enum logic [1:0] {ECC_CLEAN, ECC_SINGLE, ECC_DOUBLE} ecc_class_e;

  typedef enum logic [1:0] {WK_IDLE, WK_RD, WK_CHK, WK_WB} walk_state_e;

  typedef struct packed {
    ecc_class_e            cls;
    logic [CW_W-1:0]       fixed;
  } ecc_result_t;

  // Syndrome is the XOR of set-bit indices 1..71; bit 0 carries overall parity.
  function automatic ecc_result_t ecc_inspect(input logic [CW_W-1:0] cw);
    logic [6:0]  syn;
    logic        par;
    ecc_result_t r;
    syn = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (cw[p]) syn = syn ^ 7'(p);
    end
    par     = ^cw;
    r.fixed = cw;
    r.cls   = ECC_CLEAN;
    if (par) begin
      if (int'(syn) < CW_W) begin
        r.cls        = ECC_SINGLE;
        r.fixed[syn] = ~cw[syn];
      end else begin
        r.cls = ECC_DOUBLE;
      end
    end else if (syn != '0) begin
      r.cls = ECC_DOUBLE;
    end
    return r;
  endfunction

endpackage

// File: rtl/scrub_timer.sv
module scrub_timer #(
  parameter int TIMER_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] interval,
  input  logic               take,
  output logic               pending
);

  logic [TIMER_W-1:0] cnt_q;
  logic               tick;

  assign tick = (interval != '0) && (cnt_q >= interval - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      if (interval == '0 || tick) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
      pending <= (pending & ~take) | tick;
    end
  end

  AST_TAKE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pending) else $error("pass started without a due tick"); // R2

endmodule

// File: rtl/scrub_walker.sv
module scrub_walker
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pending,
  output logic              start_take,
  output logic              scrub_req,
  input  logic              scrub_gnt,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CW_W-1:0]   mem_wdata,
  input  logic [CW_W-1:0]   mem_rdata,
  output logic              ev_single,
  output logic              ev_double,
  output logic [ADDR_W-1:0] ev_addr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  walk_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CW_W-1:0]   fix_q;
  ecc_result_t       res;
  logic              advance;

  always_comb res = ecc_inspect(mem_rdata);

  assign scrub_req  = (state_q == WK_RD) || (state_q == WK_WB);
  assign mem_rd_en  = (state_q == WK_RD) && scrub_gnt;
  assign mem_wr_en  = (state_q == WK_WB) && scrub_gnt;
  assign mem_addr   = addr_q;
  assign mem_wdata  = fix_q;
  assign start_take = (state_q == WK_IDLE) && start_pending;
  assign ev_single  = (state_q == WK_CHK) && (res.cls == ECC_SINGLE);
  assign ev_double  = (state_q == WK_CHK) && (res.cls == ECC_DOUBLE);
  assign ev_addr    = addr_q;
  assign advance    = ((state_q == WK_CHK) && (res.cls != ECC_SINGLE)) ||
                      ((state_q == WK_WB) && scrub_gnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      addr_q  <= '0;
      fix_q   <= '0;
    end else begin
      unique case (state_q)
        WK_IDLE: if (start_pending) begin
          state_q <= WK_RD;
          addr_q  <= '0;
        end
        WK_RD:  if (scrub_gnt) state_q <= WK_CHK;
        WK_CHK: if (res.cls == ECC_SINGLE) begin
          fix_q   <= res.fixed;
          state_q <= WK_WB;
        end
        default: ;
      endcase
      if (advance) begin
        if (addr_q == LAST_ADDR) state_q <= WK_IDLE;
        else begin
          addr_q  <= addr_q + 1'b1;
          state_q <= WK_RD;
        end
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (scrub_req && !scrub_gnt) |=> (scrub_req && $stable(mem_addr)))
    else $error("request dropped or address moved before grant"); // R3

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)) else $error("read and write together"); // R3

  AST_WB_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (ecc_inspect(mem_wdata).cls == ECC_CLEAN))
    else $error("write-back word not clean"); // R5

endmodule

// File: rtl/scrub_stats.sv
module scrub_stats
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_single,
  input  logic              ev_double,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              stat_rd_en,
  input  logic [1:0]        stat_sel,
  output logic              err_single_pulse,
  output logic              err_double_pulse,
  output logic [STAT_W-1:0] stat_rd_data
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]              ev, clr;
  logic [1:0][CNT_W-1:0]   cnt_q;
  logic [1:0][STAT_W-1:0]  cnt_word;
  logic                    fail_vld;
  logic [ADDR_W-1:0]       fail_addr;
  logic [STAT_W-1:0]       fail_word;
  logic                    release_fail;

  assign ev           = {ev_double, ev_single};
  assign clr          = {stat_rd_en && (stat_sel == SEL_DB), stat_rd_en && (stat_sel == SEL_SB)};
  assign release_fail = |clr;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [CNT_W-1:0] base;
    always_comb begin
      base        = clr[g] ? '0 : cnt_q[g];
      cnt_word[g] = '0;
      cnt_word[g][CNT_W-1:0] = cnt_q[g];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                          cnt_q[g] <= '0;
      else if (ev[g] && base != CNT_MAX)   cnt_q[g] <= base + 1'b1;
      else                                 cnt_q[g] <= base;
    end

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] == CNT_MAX && !clr[g]) |=> (cnt_q[g] == CNT_MAX))
      else $error("counter wrapped"); // R7
  end

  always_comb begin
    fail_word = '0;
    fail_word[ADDR_W-1:0] = fail_addr;
    fail_word[STAT_W-1]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_vld         <= 1'b0;
      fail_addr        <= '0;
      err_single_pulse <= 1'b0;
      err_double_pulse <= 1'b0;
      stat_rd_data     <= '0;
    end else begin
      err_single_pulse <= ev_single;
      err_double_pulse <= ev_double;
      if ((ev_single || ev_double) && (!fail_vld || release_fail)) begin
        fail_vld  <= 1'b1;
        fail_addr <= ev_addr;
      end else if (release_fail) begin
        fail_vld  <= 1'b0;
      end
      if (stat_rd_en) begin
        unique case (stat_sel)
          SEL_SB:   stat_rd_data <= cnt_word[0];
          SEL_DB:   stat_rd_data <= cnt_word[1];
          SEL_FAIL: stat_rd_data <= fail_vld ? fail_word : '0;
          default:  stat_rd_data <= '0;
        endcase
      end
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_single_pulse || err_double_pulse) |=> !(err_single_pulse || err_double_pulse))
    else $error("status pulse longer than one cycle"); // R6

  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_vld && !release_fail) |=> (fail_vld && $stable(fail_addr)))
    else $error("first-failure latch changed before release"); // R9

endmodule

// File: rtl/ecc_scrubber.sv
module ecc_scrubber
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 8,
  parameter int TIMER_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] scrub_interval,
  output logic               scrub_req,
  input  logic               scrub_gnt,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [71:0]        mem_wdata,
  input  logic [71:0]        mem_rdata,
  output logic               err_single_pulse,
  output logic               err_double_pulse,
  input  logic               stat_rd_en,
  input  logic [1:0]         stat_sel,
  output logic [15:0]        stat_rd_data
);

  logic              pend, take;
  logic              ev_single, ev_double;
  logic [ADDR_W-1:0] ev_addr;

  scrub_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .interval(scrub_interval),
    .take(take), .pending(pend)
  );

  scrub_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .start_pending(pend), .start_take(take),
    .scrub_req(scrub_req), .scrub_gnt(scrub_gnt),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ev_single(ev_single), .ev_double(ev_double), .ev_addr(ev_addr)
  );

  scrub_stats #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .ev_single(ev_single), .ev_double(ev_double),
    .ev_addr(ev_addr), .stat_rd_en(stat_rd_en), .stat_sel(stat_sel),
    .err_single_pulse(err_single_pulse), .err_double_pulse(err_double_pulse),
    .stat_rd_data(stat_rd_data)
  );

endmodule

// File: tb/ecc_scrubber_bench.sv
`timescale 1ns/1ps
module ecc_scrubber_bench;

  localparam int AW    = 4;
  localparam int DEPTH = 16;
  localparam int CW    = 3;
  localparam int TW    = 12;
  localparam int SAT   = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] scrub_interval = '0;
  logic          scrub_req, scrub_gnt = 1'b1;
  logic          mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [71:0]   mem_wdata, mem_rdata;
  logic          err_single_pulse, err_double_pulse;
  logic          stat_rd_en = 1'b0;
  logic [1:0]    stat_sel = '0;
  logic [15:0]   stat_rd_data;

  always #4 clk = ~clk;

  ecc_scrubber #(.ADDR_W(AW), .CNT_W(CW), .TIMER_W(TW)) u_ecc_scrubber (
    .clk(clk), .rst_n(rst_n), .scrub_interval(scrub_interval),
    .scrub_req(scrub_req), .scrub_gnt(scrub_gnt),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .err_single_pulse(err_single_pulse), .err_double_pulse(err_double_pulse),
    .stat_rd_en(stat_rd_en), .stat_sel(stat_sel), .stat_rd_data(stat_rd_data)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string what, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Memory model: synchronous read, bench loads and DUT write-backs.
  logic [71:0] mem  [DEPTH];
  logic [71:0] gold [DEPTH];
  logic        ld_v = 1'b0;
  logic [AW-1:0] ld_a = '0;
  logic [71:0] ld_w = '0;

  always @(posedge clk) begin
    if (ld_v)           mem[ld_a] <= ld_w;
    else if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en)      mem_rdata <= mem[mem_addr];
  end

  function automatic logic [71:0] mk_cw(input logic [63:0] d);
    logic [71:0] w;
    logic [6:0]  s;
    int          k;
    w = '0; k = 0; s = '0;
    for (int p = 1; p < 72; p++) if ((p & (p - 1)) != 0) begin w[p] = d[k]; k++; end
    for (int p = 1; p < 72; p++) if (w[p]) s = s ^ 7'(p);
    for (int b = 0; b < 7; b++) w[1 << b] = s[b];
    w[0] = ^w[71:1];
    return w;
  endfunction

  // Grant source: continuous or three-in-four pseudo-random.
  bit gnt_mode = 1'b0;
  initial forever begin
    @(posedge clk); #2;
    scrub_gnt = gnt_mode ? (($urandom % 4) != 0) : 1'b1;
  end

  // Reference model, evaluated once per cycle.
  int cyc = 0, reads = 0, last_rd_cyc = 0;
  int sb_due = -1, db_due = -1;
  logic [AW-1:0] exp_next = '0;
  bit wb_pend = 1'b0;
  logic [AW-1:0] wb_addr;
  logic [71:0] wb_data;
  int m_cnt [2] = '{0, 0};
  bit f_v = 1'b0;
  logic [AW-1:0] f_a = '0;
  bit st_pend = 1'b0;
  logic [15:0] st_exp;
  bit prev_wait = 1'b0;
  logic [AW-1:0] prev_addr;
  int starts[$];
  bit ovr_chk = 1'b0;

  always @(negedge clk) if (rst_n) begin
    int diff;
    cyc++;
    if (st_pend) begin
      chk(stat_rd_data == st_exp, "R8/R9 register read vs model", 72'(stat_rd_data), 72'(st_exp));
      st_pend = 1'b0;
    end
    if (stat_rd_en) begin
      case (stat_sel)
        2'd0: st_exp = 16'(m_cnt[0]);
        2'd1: st_exp = 16'(m_cnt[1]);
        2'd2: st_exp = f_v ? (16'h8000 | 16'(f_a)) : 16'h0;
        default: st_exp = 16'h0;
      endcase
      st_pend = 1'b1;
      if (stat_sel < 2'd2) begin m_cnt[stat_sel] = 0; f_v = 1'b0; end
    end
    chk(err_single_pulse == (sb_due == cyc), "R6 single pulse", 72'(err_single_pulse), 72'(sb_due == cyc));
    chk(err_double_pulse == (db_due == cyc), "R6 double pulse", 72'(err_double_pulse), 72'(db_due == cyc));
    if (mem_rd_en || mem_wr_en)
      chk(scrub_req && scrub_gnt, "R3 access without handshake", 72'({scrub_req, scrub_gnt}), 72'(3));
    if (prev_wait) chk(scrub_req && mem_addr == prev_addr, "R3 request held", 72'(mem_addr), 72'(prev_addr));
    prev_wait = scrub_req && !scrub_gnt;
    prev_addr = mem_addr;
    if (mem_wr_en) begin
      chk(wb_pend && mem_addr == wb_addr, "R5 write-back address", 72'(mem_addr), 72'(wb_addr));
      chk(mem_wdata == wb_data, "R5 write-back data", mem_wdata, wb_data);
      wb_pend = 1'b0;
    end
    if (mem_rd_en) begin
      chk(!wb_pend, "R5 write-back missing before next read", 72'(wb_pend), 72'(0));
      chk(mem_addr == exp_next, "R4 address order", 72'(mem_addr), 72'(exp_next));
      if (mem_addr == '0) begin
        if (ovr_chk) chk(cyc - last_rd_cyc == 3, "R10 back-to-back pass gap", 72'(cyc - last_rd_cyc), 72'(3));
        starts.push_back(cyc);
      end
      diff = $countones(mem[mem_addr] ^ gold[mem_addr]);
      if (diff == 1) begin
        sb_due = cyc + 2; wb_pend = 1'b1; wb_addr = mem_addr; wb_data = gold[mem_addr];
        if (m_cnt[0] < SAT) m_cnt[0]++;
      end else if (diff == 2) begin
        db_due = cyc + 2;
        if (m_cnt[1] < SAT) m_cnt[1]++;
      end
      if (diff != 0 && !f_v) begin f_v = 1'b1; f_a = mem_addr; end
      exp_next = mem_addr + 1'b1;
      last_rd_cyc = cyc;
      reads++;
    end
  end

  task automatic load(input int a, input logic [71:0] w);
    @(posedge clk); #2; ld_v = 1'b1; ld_a = AW'(a); ld_w = w;
    @(posedge clk); #2; ld_v = 1'b0;
  endtask

  task automatic rd_stat(input logic [1:0] sel, output logic [15:0] v);
    @(posedge clk); #2; stat_rd_en = 1'b1; stat_sel = sel;
    @(posedge clk); #2; stat_rd_en = 1'b0; v = stat_rd_data;
  endtask

  task automatic one_pass();
    int n;
    n = starts.size();
    scrub_interval = TW'(300);
    while (starts.size() <= n) @(posedge clk);
    scrub_interval = '0;
    repeat (400) @(posedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!scrub_req && !mem_rd_en && !mem_wr_en, "R3 quiet after reset", 72'({scrub_req, mem_rd_en, mem_wr_en}), 72'(0));
    chk(!err_single_pulse && !err_double_pulse, "R6 no pulse after reset", 72'({err_single_pulse, err_double_pulse}), 72'(0));
    rd_stat(2'd0, v); chk(v == 16'd0, "R8 reset single count", 72'(v), 72'(0));
    rd_stat(2'd2, v); chk(v == 16'd0, "R9 reset first-failure", 72'(v), 72'(0));
    for (int a = 0; a < DEPTH; a++) begin
      gold[a] = mk_cw({$urandom, $urandom});
      load(a, gold[a]);
    end
    repeat (200) @(posedge clk);
    chk(reads == 0, "R2 interval zero starts nothing", 72'(reads), 72'(0));

    // Mixed errors under an irregular grant.
    gnt_mode = 1'b1;
    load(3,  gold[3]  ^ (72'd1 << 17));
    load(12, gold[12] ^ 72'd1);
    load(9,  gold[9]  ^ (72'd1 << 5) ^ (72'd1 << 40));
    one_pass();
    chk(mem[3] == gold[3], "R1 data-bit error corrected", mem[3], gold[3]);
    chk(mem[12] == gold[12], "R1 parity-bit error corrected", mem[12], gold[12]);
    chk(mem[9] != gold[9], "R5 double error left in place", mem[9], gold[9]);
    rd_stat(2'd2, v); chk(v == 16'h8003, "R9 first failing address", 72'(v), 72'h8003);
    rd_stat(2'd0, v); chk(v == 16'd2, "R8 single count", 72'(v), 72'(2));
    rd_stat(2'd1, v); chk(v == 16'd1, "R8 double count", 72'(v), 72'(1));
    rd_stat(2'd2, v); chk(v == 16'd0, "R9 released by counter read", 72'(v), 72'(0));
    rd_stat(2'd0, v); chk(v == 16'd0, "R8 cleared on read", 72'(v), 72'(0));

    // Periodic start with continuous grant.
    gnt_mode = 1'b0;
    n = starts.size();
    scrub_interval = TW'(100);
    while (starts.size() < n + 3) @(posedge clk);
    chk(starts[n+1] - starts[n] == 100, "R2 pass period", 72'(starts[n+1] - starts[n]), 72'(100));
    chk(starts[n+2] - starts[n+1] == 100, "R2 pass period", 72'(starts[n+2] - starts[n+1]), 72'(100));

    // Timer shorter than a pass.
    n = starts.size();
    scrub_interval = TW'(10);
    while (starts.size() < n + 2) @(posedge clk);
    ovr_chk = 1'b1;
    while (starts.size() < n + 5) @(posedge clk);
    ovr_chk = 1'b0;
    scrub_interval = '0;
    repeat (200) @(posedge clk);

    // Saturation with a double error in every word.
    rd_stat(2'd0, v);
    rd_stat(2'd1, v);
    gnt_mode = 1'b1;
    for (int a = 0; a < DEPTH; a++) load(a, gold[a] ^ (72'd1 << a) ^ (72'd1 << (a + 40)));
    one_pass();
    rd_stat(2'd2, v); chk(v == 16'h8000, "R9 first failure at address 0", 72'(v), 72'h8000);
    rd_stat(2'd1, v); chk(v == 16'(SAT), "R7 double count saturated", 72'(v), 72'(SAT));
    rd_stat(2'd1, v); chk(v == 16'd0, "R8 cleared after saturation", 72'(v), 72'(0));
    rd_stat(2'd0, v); chk(v == 16'd0, "R5 no single errors from doubles", 72'(v), 72'(0));
    rd_stat(2'd2, v); chk(v == 16'd0, "R9 latch released", 72'(v), 72'(0));

    repeat (4) @(posedge clk);
    summary();
    $finish;
  end

endmodule